// File: doc/BRIEF.md
# Reference Clock Failover Selector

This block decides which of two reference clocks feeds a downstream PLL. A free-running monitor clock samples both references through synchronizers and counts rising edges. A reference that shows no edge for a window of monitor cycles is flagged as failed. The flag is cleared only after the reference has produced a run of consecutive edges again.

A mode pin picks between two policies. In manual mode the mux select follows a select pin. In automatic mode the block moves away from the active input when that input is flagged failed, but only if the standby input is healthy. Once it has moved, it never returns by itself. An acknowledge output carries the mux state that is actually applied, updated in the same cycle as the select. The failure flags are brought out for each input.

All state lives in the monitor clock domain, and reset is synchronous and active low. The mode and select pins are expected to be driven from that domain. The two references may be asynchronous to it.

Top module: `refclk_failover`

## Requirements
- R1: In the first cycle after reset is released, `mux_sel` and `sel_ack` equal the value `man_pick` had during reset, and both bits of `fail_flag` are 0.
- R2: While `auto_en` is 0, `mux_sel` takes the value of `man_pick` one monitor cycle later: 0 routes reference 0 and 1 routes reference 1.
- R3: `sel_ack` equals `mux_sel` on every cycle, with 0 meaning reference 0 and 1 meaning reference 1.
- R4: `fail_flag[i]` is set after WIN (default 16) consecutive monitor cycles with no synchronized rising edge on input i. Bit 0 belongs to reference 0 and bit 1 to reference 1.
- R5: A set `fail_flag[i]` clears on the GOOD-th (default 8) synchronized rising edge, counted without any idle gap of WIN cycles between edges.
- R6: While `auto_en` is 1, if the active input's flag is set and the standby input's flag is clear, `mux_sel` moves to the standby input on the next cycle.
- R7: Failover in automatic mode is non-revertive: `mux_sel` stays on the new input after the original input's flag clears.
- R8: In automatic mode, while both flags are set, `mux_sel` holds its value.
- R9: While `auto_en` is 1, changes on `man_pick` have no effect on `mux_sel`.
- R10: When `auto_en` falls to 0, `mux_sel` takes the value of `man_pick` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_clk | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in0 | input | 1 | Reference clock 0 |
| ref_in1 | input | 1 | Reference clock 1 |
| auto_en | input | 1 | 1 selects automatic failover, 0 selects manual mode |
| man_pick | input | 1 | Manual choice of reference, also the starting input for automatic mode |
| mux_sel | output | 1 | Select line to the clock mux |
| sel_ack | output | 1 | Acknowledge of the applied mux state |
| fail_flag | output | 2 | Failure flag for each reference |

## Verification
The assertions take `auto_en` and `man_pick` to be synchronous to `mon_clk`, so that a value seen at one edge is the value the selector used. They also take the references to toggle no faster than half the monitor rate, since a faster reference cannot be resolved by the sampler. The stimulus changes the mode and select pins only on falling monitor edges. It generates each reference as a square wave with a period of at least four monitor cycles, and it stops and restarts a reference by freezing or resuming that wave.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic {SRC_0 = 1'b0, SRC_1 = 1'b1} src_e;

  function automatic src_e other_src(input src_e s);
    return (s == SRC_0) ? SRC_1 : SRC_0;
  endfunction
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[LAST-1:0], din};
  end

  assign rise = pipe_q[LAST-1] & ~pipe_q[LAST];
endmodule

// File: rtl/refsel_activity.sv
module refsel_activity #(
  parameter int WIN  = 16,
  parameter int GOOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic dead
);
  localparam int IW = (WIN  > 1) ? $clog2(WIN)  : 1;
  localparam int GW = (GOOD > 1) ? $clog2(GOOD) : 1;
  localparam logic [IW-1:0] IDLE_MAX = IW'(WIN - 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(GOOD - 1);

  logic [IW-1:0] idle_q;
  logic [GW-1:0] good_q;
  logic          dead_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q <= '0;
      good_q <= '0;
      dead_q <= 1'b0;
    end else if (rise) begin
      idle_q <= '0;
      if (dead_q) begin
        if (good_q == GOOD_MAX) begin
          dead_q <= 1'b0;
          good_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end else if (idle_q == IDLE_MAX) begin
      dead_q <= 1'b1;
      good_q <= '0;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign dead = dead_q;
endmodule

// File: rtl/refsel_policy.sv
module refsel_policy
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       man_pick,
  input  logic [1:0] dead,
  output logic       sel,
  output logic       ack
);
  src_e cur_q, nxt;
  logic ack_q;
  logic cur_dead, alt_dead;

  always_comb begin
    cur_dead = dead[cur_q];
    alt_dead = dead[other_src(cur_q)];
    nxt      = cur_q;
    if (!auto_en)                  nxt = src_e'(man_pick);
    else if (cur_dead && !alt_dead) nxt = other_src(cur_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= src_e'(man_pick);
      ack_q <= man_pick;
    end else begin
      cur_q <= nxt;
      ack_q <= nxt;
    end
  end

  assign sel = cur_q;
  assign ack = ack_q;
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover #(
  parameter int WIN    = 16,
  parameter int GOOD   = 8,
  parameter int STAGES = 2
) (
  input  logic       mon_clk,
  input  logic       rst_n,
  input  logic       ref_in0,
  input  logic       ref_in1,
  input  logic       auto_en,
  input  logic       man_pick,
  output logic       mux_sel,
  output logic       sel_ack,
  output logic [1:0] fail_flag
);
  localparam int NREF = 2;

  logic [NREF-1:0] refs;
  logic [NREF-1:0] rises;
  logic [NREF-1:0] deads;

  assign refs = {ref_in1, ref_in0};

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    refsel_sync #(.STAGES(STAGES)) u_sync (
      .clk(mon_clk), .rst_n(rst_n), .din(refs[g]), .rise(rises[g])
    );
    refsel_activity #(.WIN(WIN), .GOOD(GOOD)) u_act (
      .clk(mon_clk), .rst_n(rst_n), .rise(rises[g]), .dead(deads[g])
    );
  end

  refsel_policy u_pol (
    .clk(mon_clk), .rst_n(rst_n), .auto_en(auto_en), .man_pick(man_pick),
    .dead(deads), .sel(mux_sel), .ack(sel_ack)
  );

  assign fail_flag = deads;
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
  input logic       mon_clk,
  input logic       rst_n,
  input logic       auto_en,
  input logic       man_pick,
  input logic       mux_sel,
  input logic       sel_ack,
  input logic [1:0] fail_flag
);
  // R3
  ack_agree_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    sel_ack == mux_sel);

  // R2
  manual_follow_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    !auto_en |=> mux_sel == $past(man_pick));

  // R6
  failover_move_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (auto_en && fail_flag[mux_sel] && !fail_flag[!mux_sel]) |=> mux_sel != $past(mux_sel));

  // R7
  no_revert_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (auto_en && !fail_flag[mux_sel]) |=> $stable(mux_sel));

  // R8
  both_dead_hold_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (auto_en && fail_flag[0] && fail_flag[1]) |=> $stable(mux_sel));
endmodule

bind refclk_failover refclk_failover_chk u_chk (
  .mon_clk(mon_clk), .rst_n(rst_n), .auto_en(auto_en), .man_pick(man_pick),
  .mux_sel(mux_sel), .sel_ack(sel_ack), .fail_flag(fail_flag)
);

// File: tb/refclk_failover_test.sv
module refclk_failover_test;
  localparam int WIN = 16;
  localparam int GOOD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in0 = 1'b0, ref_in1 = 1'b0;
  logic auto_en = 1'b0, man_pick = 1'b1;
  logic mux_sel, sel_ack;
  logic [1:0] fail_flag;

  int checks = 0, errors = 0, cycles = 0;
  bit run0 = 1'b0, run1 = 1'b0;
  int cnt0 = 0, cnt1 = 0;

  // behavioural reference model
  int h1[2], h2[2], h3[2], idle[2], good[2], mfail[2];
  int msel = 0;
  bit mvalid = 1'b0;

  always #5 clk = ~clk;

  refclk_failover uut (
    .mon_clk(clk), .rst_n(rst_n), .ref_in0(ref_in0), .ref_in1(ref_in1),
    .auto_en(auto_en), .man_pick(man_pick), .mux_sel(mux_sel),
    .sel_ack(sel_ack), .fail_flag(fail_flag)
  );

  always @(posedge clk) begin
    int of[2];
    int r[2];
    int os;
    r[0] = ref_in0; r[1] = ref_in1;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        h1[i] = 0; h2[i] = 0; h3[i] = 0; idle[i] = 0; good[i] = 0; mfail[i] = 0;
      end
      msel = man_pick;
    end else begin
      of[0] = mfail[0]; of[1] = mfail[1]; os = msel;
      for (int i = 0; i < 2; i++) begin
        bit e;
        e = (h2[i] == 1) && (h3[i] == 0);
        h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = r[i];
        if (e) begin
          idle[i] = 0;
          if (mfail[i] == 1) begin
            good[i]++;
            if (good[i] == GOOD) begin mfail[i] = 0; good[i] = 0; end
          end
        end else if (idle[i] == WIN - 1) begin
          mfail[i] = 1; good[i] = 0;
        end else idle[i]++;
      end
      if (!auto_en) msel = man_pick;
      else if (of[os] == 1 && of[1-os] == 0) msel = 1 - os;
    end
    mvalid = 1'b1;
  end

  // reference waveforms, period 4 and 6 monitor cycles
  always @(negedge clk) begin
    if (run0) begin cnt0++; if (cnt0 >= 2) begin cnt0 = 0; ref_in0 <= ~ref_in0; end end
    if (run1) begin cnt1++; if (cnt1 >= 3) begin cnt1 = 0; ref_in1 <= ~ref_in1; end end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (mvalid) begin
      checks++;
      if (mux_sel !== msel[0]) begin
        errors++; $display("FAIL R2/R6 mux_sel actual %0b expected %0d", mux_sel, msel);
      end
      checks++;
      if (sel_ack !== mux_sel) begin
        errors++; $display("FAIL R3 sel_ack actual %0b expected %0b", sel_ack, mux_sel);
      end
      checks++;
      if (fail_flag !== {mfail[1][0], mfail[0][0]}) begin
        errors++; $display("FAIL R4 fail_flag actual %b expected %0d%0d", fail_flag, mfail[1], mfail[0]);
      end
    end
    if (cycles > 20000) begin
      errors++; $display("FAIL watchdog actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    expect_bit("R1 mux_sel after reset", mux_sel, 1'b1);
    expect_bit("R1 fail0 after reset", fail_flag[0], 1'b0);
    expect_bit("R1 fail1 after reset", fail_flag[1], 1'b0);
    run0 = 1'b1; run1 = 1'b1;
    man_pick = 1'b0;
    wait_cyc(2);
    expect_bit("R2 manual pick 0", mux_sel, 1'b0);
    man_pick = 1'b1;
    wait_cyc(2);
    expect_bit("R2 manual pick 1", mux_sel, 1'b1);
    man_pick = 1'b0;
    wait_cyc(30);
    auto_en = 1'b1;
    wait_cyc(3);
    man_pick = 1'b1;
    wait_cyc(5);
    expect_bit("R9 pick ignored in auto", mux_sel, 1'b0);
    run0 = 1'b0;
    wait_cyc(30);
    expect_bit("R4 fail0 raised", fail_flag[0], 1'b1);
    expect_bit("R6 moved to ref1", mux_sel, 1'b1);
    expect_bit("R3 ack follows", sel_ack, 1'b1);
    run0 = 1'b1;
    wait_cyc(60);
    expect_bit("R5 fail0 cleared", fail_flag[0], 1'b0);
    expect_bit("R7 stays on ref1", mux_sel, 1'b1);
    run0 = 1'b0;
    wait_cyc(30);
    run1 = 1'b0;
    wait_cyc(30);
    expect_bit("R8 both failed flag1", fail_flag[1], 1'b1);
    expect_bit("R8 hold on ref1", mux_sel, 1'b1);
    man_pick = 1'b0;
    auto_en = 1'b0;
    wait_cyc(2);
    expect_bit("R10 back to manual", mux_sel, 1'b0);
    wait_cyc(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule